// File: doc/BRIEF.md
# Quad-Sample Waveform Playback Engine

This engine turns a stream of waveform commands into a continuous stream of four-sample words for a digital-to-analog converter. Commands arrive through a shallow queue with a valid/ready handshake. For each command the engine either reads a block of consecutive words from an external synchronous waveform RAM, repeats the word found at one address for a set number of cycles, or stalls until a trigger or a sync pulse is seen. Each RAM word holds four 16-bit samples, so one word is produced per clock.

The RAM has one cycle of read latency and the output is registered, so a word appears on the converter port two cycles after its read address is presented. Commands queued behind a playing one start with no idle cycle between them. When nothing is playing, the output is held at zero (mid-scale) and its valid flag is low.

Top module: `wave_play_engine`

## Requirements
- R1: After reset, dac_data is zero, dac_valid is low, idle is high and cmd_ready is high.
- R2: A command word carries its start address in bits 23:0, a 21-bit count in bits 44:24, the hold flag in bit 45 and the mode in bits 47:46 (0 play, 1 wait for trigger, 2 wait for sync, 3 no-op).
- R3: A play command with count N presents N read addresses on ram_addr, one per clock, counting up from the start address, and each RAM word read appears on dac_data with dac_valid high two clocks after its address.
- R4: A play command with the hold flag set reads the start address on each of its N cycles, so the same word is output N times.
- R5: Whenever dac_valid is low, dac_data is zero.
- R6: A queued command starts issuing on the clock after the last read of the current command, leaving no gap in dac_valid between back-to-back play commands.
- R7: A play command with a count of zero, and a mode 3 command, each occupy the engine for exactly one clock and produce no output word.
- R8: A wait-for-trigger command holds back the following commands until trig_in is high during a cycle in which that command is active; trigger pulses at other times and sync pulses have no effect on it.
- R9: A wait-for-sync command holds back the following commands until sync_in is high while it is active; trigger pulses have no effect on it.
- R10: The queue holds FIFO_DEPTH commands; cmd_ready is low exactly when it is full, and commands execute in the order accepted.
- R11: idle is high exactly when the queue is empty and no command is active.
- R12: The four 16-bit sample lanes of a RAM word pass to dac_data unchanged, lane 0 in bits 15:0, each sample being a 14-bit signed value sign-extended to 16 bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command word offered |
| cmd_ready | output | 1 | Queue can accept a command |
| cmd_word | input | 48 | Command word (layout in R2) |
| trig_in | input | 1 | Trigger pulse, synchronous |
| sync_in | input | 1 | Sync pulse, synchronous |
| ram_rd_en | output | 1 | Waveform RAM read enable |
| ram_addr | output | 24 | Waveform RAM word address |
| ram_rd_data | input | 64 | RAM word, valid one clock after ram_rd_en |
| dac_valid | output | 1 | dac_data holds a waveform word |
| dac_data | output | 64 | Four samples to the converter |
| idle | output | 1 | Queue empty and no command active |

## Verification
The assertions take for granted that the waveform RAM returns its word exactly one clock after a read enable, and that trig_in and sync_in are synchronous to clk. The bench models the RAM as a one-cycle synchronous array filled with sign-extended 14-bit patterns, and drives the handshake and the pulses one time unit after each rising edge, holding pulses for a single clock. Pulses are also sent while the engine is idle or waiting on the other event, so the stalls are checked against stray events that arrive within those same assumptions.

// File: rtl/wpe_pkg.sv
package wpe_pkg;
  parameter int ADDR_W = 24;
  parameter int CNT_W  = 21;
  localparam int CMD_W = 3 + CNT_W + ADDR_W;

  typedef enum logic [1:0] {
    OP_PLAY = 2'd0,
    OP_TRIG = 2'd1,
    OP_SYNC = 2'd2,
    OP_NOP  = 2'd3
  } wpe_op_e;

  typedef struct packed {
    wpe_op_e           op;
    logic              hold;
    logic [CNT_W-1:0]  count;
    logic [ADDR_W-1:0] addr;
  } wpe_cmd_t;
endpackage

// File: rtl/wpe_cmd_fifo.sv
module wpe_cmd_fifo #(
  parameter int W     = 48,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         empty,
  output logic         full
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wr_ptr, rd_ptr;
  logic [PW:0]   used;

  assign empty = (used == '0);
  assign full  = (used == (PW+1)'(DEPTH));
  assign dout  = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      used   <= '0;
    end else begin
      if (push) wr_ptr <= (wr_ptr == PW'(DEPTH-1)) ? '0 : wr_ptr + PW'(1);
      if (pop)  rd_ptr <= (rd_ptr == PW'(DEPTH-1)) ? '0 : rd_ptr + PW'(1);
      if (push && !pop)      used <= used + (PW+1)'(1);
      else if (pop && !push) used <= used - (PW+1)'(1);
    end
  end
endmodule

// File: rtl/wpe_seq.sv
module wpe_seq
  import wpe_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  wpe_cmd_t          head,
  input  logic              head_ok,
  input  logic              trig_in,
  input  logic              sync_in,
  output logic              pop,
  output logic              rd_en,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              act,
  output wpe_op_e           op,
  output logic              hold
);
  logic [CNT_W-1:0]  left;
  logic [ADDR_W-1:0] addr;
  logic              done;
  logic              issue;

  always_comb begin
    issue = act && (op == OP_PLAY) && (left != '0);
    unique case (op)
      OP_PLAY: done = (left <= CNT_W'(1));
      OP_TRIG: done = trig_in;
      OP_SYNC: done = sync_in;
      default: done = 1'b1;
    endcase
    done = done && act;
    pop  = head_ok && (!act || done);
  end

  assign rd_en   = issue;
  assign rd_addr = addr;

  always_ff @(posedge clk) begin
    if (rst) begin
      act  <= 1'b0;
      op   <= OP_PLAY;
      hold <= 1'b0;
      left <= '0;
      addr <= '0;
    end else if (pop) begin
      act  <= 1'b1;
      op   <= head.op;
      hold <= head.hold;
      left <= head.count;
      addr <= head.addr;
    end else begin
      if (done) act <= 1'b0;
      if (issue) begin
        left <= left - CNT_W'(1);
        if (!hold) addr <= addr + ADDR_W'(1);
      end
    end
  end
endmodule

// File: rtl/wpe_out_pipe.sv
module wpe_out_pipe #(
  parameter int WORD_W = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              issued,
  input  logic [WORD_W-1:0] rd_data,
  output logic              dac_valid,
  output logic [WORD_W-1:0] dac_data
);
  logic in_flight;

  always_ff @(posedge clk) begin
    if (rst) begin
      in_flight <= 1'b0;
      dac_valid <= 1'b0;
      dac_data  <= '0;
    end else begin
      in_flight <= issued;
      dac_valid <= in_flight;
      dac_data  <= in_flight ? rd_data : '0;
    end
  end
endmodule

// File: rtl/wave_play_engine.sv
module wave_play_engine
  import wpe_pkg::*;
#(
  parameter int FIFO_DEPTH = 4,
  parameter int LANES      = 4,
  parameter int SAMPLE_W   = 16,
  localparam int WORD_W    = LANES * SAMPLE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [CMD_W-1:0]  cmd_word,
  input  logic              trig_in,
  input  logic              sync_in,
  output logic              ram_rd_en,
  output logic [ADDR_W-1:0] ram_addr,
  input  logic [WORD_W-1:0] ram_rd_data,
  output logic              dac_valid,
  output logic [WORD_W-1:0] dac_data,
  output logic              idle
);
  logic [CMD_W-1:0] head_bits;
  logic             q_empty, q_full, q_pop;
  logic             seq_act, seq_hold;
  wpe_op_e          seq_op;

  assign cmd_ready = !q_full;

  wpe_cmd_fifo #(.W(CMD_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk  (clk),
    .rst  (rst),
    .push (cmd_valid && !q_full),
    .din  (cmd_word),
    .pop  (q_pop),
    .dout (head_bits),
    .empty(q_empty),
    .full (q_full)
  );

  wpe_seq u_seq (
    .clk    (clk),
    .rst    (rst),
    .head   (wpe_cmd_t'(head_bits)),
    .head_ok(!q_empty),
    .trig_in(trig_in),
    .sync_in(sync_in),
    .pop    (q_pop),
    .rd_en  (ram_rd_en),
    .rd_addr(ram_addr),
    .act    (seq_act),
    .op     (seq_op),
    .hold   (seq_hold)
  );

  wpe_out_pipe #(.WORD_W(WORD_W)) u_out (
    .clk      (clk),
    .rst      (rst),
    .issued   (ram_rd_en),
    .rd_data  (ram_rd_data),
    .dac_valid(dac_valid),
    .dac_data (dac_data)
  );

  assign idle = q_empty && !seq_act;
endmodule

// File: rtl/wpe_checker.sv
module wpe_checker
  import wpe_pkg::*;
#(
  parameter int WORD_W = 64
) (
  input logic              clk,
  input logic              rst,
  input logic              cmd_ready,
  input logic              ram_rd_en,
  input logic [ADDR_W-1:0] ram_addr,
  input logic              dac_valid,
  input logic [WORD_W-1:0] dac_data,
  input logic              idle,
  input logic              trig_in,
  input logic              sync_in,
  input logic              act,
  input logic [1:0]        op,
  input logic              hold,
  input logic              pop
);
  assert_zero_out_R5: assert property (@(posedge clk) disable iff (rst)
    !dac_valid |-> (dac_data == '0));

  assert_latency_R3: assert property (@(posedge clk) disable iff (rst)
    dac_valid == $past(ram_rd_en, 2));

  assert_addr_step_R3: assert property (@(posedge clk) disable iff (rst)
    (ram_rd_en && $past(ram_rd_en) && !$past(pop) && !hold)
      |-> (ram_addr == $past(ram_addr) + ADDR_W'(1)));

  assert_addr_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (ram_rd_en && $past(ram_rd_en) && !$past(pop) && hold)
      |-> $stable(ram_addr));

  assert_trig_wait_R8: assert property (@(posedge clk) disable iff (rst)
    (act && op == OP_TRIG && !trig_in) |=> (act && op == OP_TRIG));

  assert_sync_wait_R9: assert property (@(posedge clk) disable iff (rst)
    (act && op == OP_SYNC && !sync_in) |=> (act && op == OP_SYNC));

  assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (rst)
    idle |-> (!ram_rd_en && cmd_ready));
endmodule

bind wave_play_engine wpe_checker #(.WORD_W(WORD_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .cmd_ready(cmd_ready),
  .ram_rd_en(ram_rd_en),
  .ram_addr (ram_addr),
  .dac_valid(dac_valid),
  .dac_data (dac_data),
  .idle     (idle),
  .trig_in  (trig_in),
  .sync_in  (sync_in),
  .act      (seq_act),
  .op       (seq_op),
  .hold     (seq_hold),
  .pop      (q_pop)
);

// File: tb/sim_wave_play_engine.sv
module sim_wave_play_engine;
  localparam int DEPTH = 4;
  localparam int LIMIT = 20000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cmd_valid = 1'b0;
  logic [47:0] cmd_word = '0;
  logic        trig_in = 1'b0, sync_in = 1'b0;
  logic        cmd_ready, ram_rd_en, dac_valid, idle;
  logic [23:0] ram_addr;
  logic [63:0] ram_q, dac_data;

  int tests = 0, fails = 0, cyc = 0;

  always #10 clk = ~clk;

  wave_play_engine #(.FIFO_DEPTH(DEPTH)) u0 (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_word(cmd_word), .trig_in(trig_in), .sync_in(sync_in),
    .ram_rd_en(ram_rd_en), .ram_addr(ram_addr), .ram_rd_data(ram_q),
    .dac_valid(dac_valid), .dac_data(dac_data), .idle(idle)
  );

  function automatic logic [63:0] memf(input int a);
    logic [63:0] w;
    for (int i = 0; i < 4; i++) begin
      int v;
      v = ((a * 37 + i * 1103 + 17) % 16384) - 8192;
      w[i*16 +: 16] = 16'(v);
    end
    return w;
  endfunction

  logic [63:0] ram [256];
  initial for (int i = 0; i < 256; i++) ram[i] = memf(i);
  always_ff @(posedge clk) if (ram_rd_en) ram_q <= ram[ram_addr[7:0]];

  function automatic logic [47:0] mk(input int op, input bit hold,
                                     input int cnt, input int addr);
    return {2'(op), hold, 21'(cnt), 24'(addr)};
  endfunction

  task automatic chk(input string tag, input logic [63:0] act,
                     input logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // behavioural reference model
  logic [47:0] q[$];
  bit          m_act, m_hold, m_v1, m_dv, m_rdy, m_idle;
  int          m_op, m_cnt;
  logic [23:0] m_addr, m_a1;
  logic [63:0] m_dd;

  // window monitors
  int vcnt, first_v, last_v, nrdy, refmis;
  logic [63:0] refw;
  bit use_ref;

  task automatic clear_mon();
    vcnt = 0; first_v = -1; last_v = -1; nrdy = 0; refmis = 0; use_ref = 0;
  endtask

  always @(negedge clk) begin
    cyc++;
    if (rst) begin
      q.delete();
      m_act = 0; m_hold = 0; m_v1 = 0; m_dv = 0; m_op = 0; m_cnt = 0;
      m_addr = '0; m_a1 = '0; m_dd = '0; m_rdy = 1; m_idle = 1;
    end else begin
      bit issue, done, pop, rdy;
      logic [47:0] h;
      chk("R3/R12 dac_data", dac_data, m_dd);
      chk("R5 dac_valid", 64'(dac_valid), 64'(m_dv));
      chk("R11 idle", 64'(idle), 64'(m_idle));
      chk("R10 cmd_ready", 64'(cmd_ready), 64'(m_rdy));
      if (dac_valid) begin
        vcnt++;
        if (first_v < 0) first_v = cyc;
        last_v = cyc;
        if (use_ref && dac_data !== refw) refmis++;
      end
      if (!cmd_ready) nrdy++;
      // advance model by one clock
      issue = m_act && m_op == 0 && m_cnt != 0;
      case (m_op)
        0: done = m_cnt <= 1;
        1: done = trig_in;
        2: done = sync_in;
        default: done = 1;
      endcase
      done = done && m_act;
      rdy  = q.size() < DEPTH;
      pop  = (q.size() > 0) && (!m_act || done);
      m_dv = m_v1;
      m_dd = m_v1 ? memf(int'(m_a1[7:0])) : '0;
      m_v1 = issue;
      m_a1 = m_addr;
      if (issue) begin
        m_cnt--;
        if (!m_hold) m_addr = m_addr + 24'd1;
      end
      if (pop) begin
        h = q.pop_front();
        m_act = 1; m_op = int'(h[47:46]); m_hold = h[45];
        m_cnt = int'(h[44:24]); m_addr = h[23:0];
      end else if (done) m_act = 0;
      if (cmd_valid && rdy) q.push_back(cmd_word);
      m_rdy  = q.size() < DEPTH;
      m_idle = (q.size() == 0) && !m_act;
    end
  end

  task automatic push(input logic [47:0] w);
    bit r;
    cmd_word = w; cmd_valid = 1;
    forever begin
      @(negedge clk); r = cmd_ready;
      @(posedge clk); #1;
      if (r) break;
    end
    cmd_valid = 0;
  endtask

  task automatic pulse_trig();
    @(posedge clk); #1 trig_in = 1;
    @(posedge clk); #1 trig_in = 0;
  endtask

  task automatic pulse_sync();
    @(posedge clk); #1 sync_in = 1;
    @(posedge clk); #1 sync_in = 0;
  endtask

  task automatic wait_idle();
    do @(negedge clk); while (!idle);
    repeat (4) @(posedge clk);
    #1;
  endtask

  always @(posedge clk) if (cyc >= LIMIT) begin
    fails++;
    $display("FAIL watchdog actual=%0d expected<%0d", cyc, LIMIT);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    clear_mon();
    repeat (3) @(posedge clk);
    #1 rst = 0;
    @(negedge clk);
    chk("R1 dac_data", dac_data, 64'd0);
    chk("R1 dac_valid", 64'(dac_valid), 64'd0);
    chk("R1 idle", 64'(idle), 64'd1);
    chk("R1 cmd_ready", 64'(cmd_ready), 64'd1);
    @(posedge clk); #1;

    // R2/R3: plain play, address and count fields
    clear_mon();
    push(mk(0, 0, 5, 10));
    chk("R11 busy idle", 64'(idle), 64'd0);
    wait_idle();
    chk("R3 play words", 64'(vcnt), 64'd5);
    chk("R2 first word", 64'(first_v >= 0), 64'd1);

    // R4: hold flag repeats one word
    clear_mon(); refw = memf(20); use_ref = 1;
    push(mk(0, 1, 4, 20));
    wait_idle();
    chk("R4 hold words", 64'(vcnt), 64'd4);
    chk("R4 hold mismatches", 64'(refmis), 64'd0);

    // R6: back-to-back commands, no gap
    clear_mon();
    push(mk(0, 0, 3, 40));
    push(mk(0, 1, 2, 50));
    push(mk(0, 0, 4, 60));
    wait_idle();
    chk("R6 total words", 64'(vcnt), 64'd9);
    chk("R6 no gap", 64'(last_v - first_v + 1), 64'd9);

    // R7: zero count and no-op
    clear_mon();
    push(mk(0, 0, 0, 70));
    push(mk(3, 0, 7, 80));
    wait_idle();
    chk("R7 zero-count words", 64'(vcnt), 64'd0);

    // R8: trigger wait, stray trigger before and sync during
    clear_mon();
    pulse_trig();
    push(mk(1, 0, 0, 0));
    push(mk(0, 0, 3, 90));
    pulse_sync();
    repeat (10) @(posedge clk); #1;
    chk("R8 stalled words", 64'(vcnt), 64'd0);
    pulse_trig();
    wait_idle();
    chk("R8 after trig words", 64'(vcnt), 64'd3);

    // R9: sync wait ignores triggers
    clear_mon();
    push(mk(2, 0, 0, 0));
    push(mk(0, 0, 3, 100));
    pulse_trig();
    repeat (6) @(posedge clk); #1;
    chk("R9 stalled words", 64'(vcnt), 64'd0);
    pulse_sync();
    wait_idle();
    chk("R9 after sync words", 64'(vcnt), 64'd3);

    // R10: fill the queue behind a long command
    clear_mon();
    push(mk(0, 0, 40, 120));
    for (int k = 0; k < 6; k++) push(mk(0, k[0], 2, 200 + k));
    wait_idle();
    chk("R10 backpressure seen", 64'(nrdy > 0), 64'd1);
    chk("R10 total words", 64'(vcnt), 64'd52);

    // R12: lanes sign extended, address wrap of low bits
    clear_mon(); refw = memf(255); use_ref = 1;
    push(mk(0, 1, 1, 255));
    wait_idle();
    chk("R12 lane word", 64'(refmis), 64'd0);
    chk("R12 lane0 sign", 64'(refw[15] == refw[13] && refw[14] == refw[13]), 64'd1);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule